// File: doc/BRIEF.md
# Interrupt Controller Command Word Sequencer

This block is the byte-wide register front end of an eight-line interrupt controller. A processor reaches it through a one-bit address, separate write and read strobes, and 8-bit write and read data. The block decodes the bytes it receives into configuration and commands for a separate priority block. That priority block holds the request and in-service registers and resolves which line wins.

A write to the control address with bit 4 set starts an initialisation sequence. A small state machine then reads the following data-address writes in a fixed order. The states are `ST_READY` (normal mode), `ST_WAIT_BASE` (waiting for the vector base), `ST_WAIT_CFG2` (waiting for the second configuration byte) and `ST_WAIT_CFG3` (waiting for the optional mode byte). The transitions are:

- start: any state goes to `ST_WAIT_BASE` on an init write.
- base_taken: `ST_WAIT_BASE` goes to `ST_WAIT_CFG2`.
- cfg2_more: `ST_WAIT_CFG2` goes to `ST_WAIT_CFG3` when a mode byte was announced.
- cfg2_done: `ST_WAIT_CFG2` goes to `ST_READY` when no mode byte was announced.
- cfg3_done: `ST_WAIT_CFG3` goes to `ST_READY`.

In `ST_READY`, a data-address write loads the mask. Other control-address writes are end-of-interrupt, priority and selection commands. Poll mode turns the next read into an acknowledge of the highest active line.

Every output is registered. Commands to the priority block are one-cycle pulses on `cmd_op`/`cmd_line`, issued in the cycle after the strobe.

Top module: `intc_cmd_seq`

## Requirements
- R1: A control-address (bus_addr=0) write with bit 4 set starts initialisation. In the next cycle: the state is `ST_WAIT_BASE`; mask, vector base, auto_eoi, nested_mode, rot_auto_eoi, special_mask, read_isr and poll_armed are all 0; cmd_op is 1 (INIT) for one cycle. Data bit 0 is kept as the "mode byte follows" flag.
- R2: In `ST_WAIT_BASE`, a data-address (bus_addr=1) write sets vec_base to the data with bits 2:0 cleared, and moves to `ST_WAIT_CFG2`.
- R3: In `ST_WAIT_CFG2`, a data-address write moves to `ST_WAIT_CFG3` if the flag is set, or to `ST_READY` if it is not. The written data changes no output.
- R4: In `ST_WAIT_CFG3`, a data-address write sets nested_mode from data bit 4 and auto_eoi from data bit 1, then returns to `ST_READY`.
- R5: In `ST_READY`, a data-address write loads mask_out with the data. Data-address writes in any other state leave mask_out unchanged.
- R6: A control write with bit 4 = 0 and bit 3 = 1 is a selection command. Bit 2 = 1 arms poll. Bit 1 = 1 copies bit 0 into read_isr. Bit 6 = 1 copies bit 5 into special_mask. Fields whose enable bit is 0 keep their value.
- R7: A control write with bits 4 and 3 both 0 decodes bits 7:5 as follows. Codes 0 and 4 set rot_auto_eoi from bit 7 and issue no command. Code 1 issues cmd_op 2 (non-specific EOI). Code 5 issues cmd_op 3 (rotating non-specific EOI). Code 3 issues cmd_op 4 (specific EOI). Code 6 issues cmd_op 5 (set lowest priority). Code 7 issues cmd_op 6 (rotating specific EOI). Code 2 issues nothing. cmd_line is bits 2:0 for codes 3, 6 and 7, and 0 for the other codes.
- R8: A read while poll is armed, at either address, works as follows. If pend_valid is 1, bus_rdata becomes pend_line (upper bits 0) and cmd_op 7 (POLL_ACK) is issued with cmd_line = pend_line. If pend_valid is 0, bus_rdata becomes 7 and no command is issued. In both cases poll_armed clears.
- R9: A read with poll not armed returns isr_in at address 0 when read_isr is 1, req_in at address 0 when read_isr is 0, and mask_out at address 1. bus_rdata holds its value until the next read.
- R10: After reset the block is in `ST_READY`. vec_base is 0, all mode bits are 0, read_isr is 0 (request register), mask_out is 0, bus_rdata is 0 and cmd_op is 0.
- R11: cmd_op is 0 in every cycle that does not follow a strobe. If bus_wr and bus_rd are both high, the write is taken and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 = control address, 1 = data address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, held between reads |
| req_in | input | 8 | Request register from the priority block |
| isr_in | input | 8 | In-service register from the priority block |
| pend_valid | input | 1 | Priority block has a winning line |
| pend_line | input | 3 | Winning line number |
| vec_base | output | 8 | Vector base (bits 2:0 always 0) |
| mask_out | output | 8 | Interrupt mask |
| auto_eoi | output | 1 | Automatic end of interrupt enabled |
| nested_mode | output | 1 | Special fully nested mode enabled |
| rot_auto_eoi | output | 1 | Rotate on automatic end of interrupt |
| special_mask | output | 1 | Special mask mode |
| read_isr | output | 1 | Address-0 read selects the in-service register |
| poll_armed | output | 1 | Next read is a poll |
| cmd_op | output | 3 | One-cycle command to the priority block (0 = none) |
| cmd_line | output | 3 | Line argument of cmd_op |

## Verification
A wrong sequencer state cannot be seen directly. It shows up on the next data-address write: either the mask moves when it should hold, or the byte lands in vec_base, auto_eoi or nested_mode instead of the mask. That write is one cycle after the fault at the earliest, and possibly several writes later. For this reason the bench replays full sequences, with and without the mode byte, and compares every output against a behavioural model on every clock. A wrongly armed or unarmed poll shows up on the next read, as a wrong bus_rdata or as a missing or extra POLL_ACK pulse. Command decode faults show up one cycle after the write, on cmd_op and cmd_line.

// File: rtl/intc_seq_pkg.sv
package intc_seq_pkg;

    localparam int DATA_W = 8;
    localparam int LINE_W = $clog2(DATA_W);
    localparam int OP_W   = 3;

    // Control-address field positions (behaviour depends on them)
    localparam int B_INIT    = 4;
    localparam int B_SELCMD  = 3;
    localparam int B_POLL    = 2;
    localparam int B_RSEL_EN = 1;
    localparam int B_RSEL    = 0;
    localparam int B_SMM_EN  = 6;
    localparam int B_SMM     = 5;
    localparam int B_FOURTH  = 0;
    localparam int B_NESTED  = 4;
    localparam int B_AEOI    = 1;
    localparam int CODE_LSB  = 5;

    localparam logic [DATA_W-1:0] BASE_MASK = ~DATA_W'((1 << LINE_W) - 1);

    typedef enum logic [1:0] {
        ST_READY     = 2'd0,
        ST_WAIT_BASE = 2'd1,
        ST_WAIT_CFG2 = 2'd2,
        ST_WAIT_CFG3 = 2'd3
    } seq_state_t;

    typedef enum logic [OP_W-1:0] {
        OP_NONE      = 3'd0,
        OP_INIT      = 3'd1,
        OP_EOI_NS    = 3'd2,
        OP_EOI_ROTNS = 3'd3,
        OP_EOI_SPEC  = 3'd4,
        OP_SET_PRIO  = 3'd5,
        OP_EOI_ROTSP = 3'd6,
        OP_POLL_ACK  = 3'd7
    } cmd_op_t;

endpackage

// File: rtl/intc_init_fsm.sv
module intc_init_fsm
    import intc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_dat,
    input  logic [DATA_W-1:0] wdata,
    output logic              init_start,
    output logic [DATA_W-1:0] vec_base,
    output logic [DATA_W-1:0] mask_q,
    output logic              auto_eoi,
    output logic              nested_mode
);

    seq_state_t state_q, state_d;
    logic       fourth_q;

    assign init_start = wr_ctl && wdata[B_INIT];

    always_comb begin
        state_d = state_q;
        if (init_start) begin
            state_d = ST_WAIT_BASE;
        end else if (wr_dat) begin
            unique case (state_q)
                ST_READY:     state_d = ST_READY;
                ST_WAIT_BASE: state_d = ST_WAIT_CFG2;
                ST_WAIT_CFG2: state_d = fourth_q ? ST_WAIT_CFG3 : ST_READY;
                ST_WAIT_CFG3: state_d = ST_READY;
                default:      state_d = ST_READY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fourth_q    <= 1'b0;
            vec_base    <= '0;
            mask_q      <= '0;
            auto_eoi    <= 1'b0;
            nested_mode <= 1'b0;
        end else if (init_start) begin
            fourth_q    <= wdata[B_FOURTH];
            vec_base    <= '0;
            mask_q      <= '0;
            auto_eoi    <= 1'b0;
            nested_mode <= 1'b0;
        end else if (wr_dat) begin
            unique case (state_q)
                ST_READY:     mask_q   <= wdata;
                ST_WAIT_BASE: vec_base <= wdata & BASE_MASK;
                ST_WAIT_CFG2: ;
                ST_WAIT_CFG3: begin
                    nested_mode <= wdata[B_NESTED];
                    auto_eoi    <= wdata[B_AEOI];
                end
                default: ;
            endcase
        end
    end

    assert_init_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |=> (state_q == ST_WAIT_BASE && mask_q == '0 && vec_base == '0
                        && !auto_eoi && !nested_mode));

    assert_base_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && !wr_ctl && state_q == ST_WAIT_BASE)
        |=> (vec_base == ($past(wdata) & BASE_MASK) && state_q == ST_WAIT_CFG2));

    assert_cfg2_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && !wr_ctl && state_q == ST_WAIT_CFG2 && !fourth_q) |=> state_q == ST_READY);

    assert_cfg3_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && !wr_ctl && state_q == ST_WAIT_CFG3) |=> state_q == ST_READY);

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && !wr_ctl && state_q != ST_READY) |=> $stable(mask_q));

endmodule

// File: rtl/intc_ocw_decode.sv
module intc_ocw_decode
    import intc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              init_start,
    input  logic              poll_take,
    output logic              poll_armed,
    output logic              read_isr,
    output logic              special_mask,
    output logic              rot_auto_eoi,
    output cmd_op_t           wr_op,
    output logic [LINE_W-1:0] wr_line
);

    logic       is_sel, is_ocw2;
    logic [2:0] code;

    assign is_sel  = wr_ctl && !wdata[B_INIT] &&  wdata[B_SELCMD];
    assign is_ocw2 = wr_ctl && !wdata[B_INIT] && !wdata[B_SELCMD];
    assign code    = wdata[CODE_LSB +: 3];

    always_comb begin
        wr_op   = OP_NONE;
        wr_line = '0;
        if (is_ocw2) begin
            unique case (code)
                3'd1: wr_op = OP_EOI_NS;
                3'd5: wr_op = OP_EOI_ROTNS;
                3'd3: begin wr_op = OP_EOI_SPEC;  wr_line = wdata[LINE_W-1:0]; end
                3'd6: begin wr_op = OP_SET_PRIO;  wr_line = wdata[LINE_W-1:0]; end
                3'd7: begin wr_op = OP_EOI_ROTSP; wr_line = wdata[LINE_W-1:0]; end
                default: wr_op = OP_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_armed   <= 1'b0;
            read_isr     <= 1'b0;
            special_mask <= 1'b0;
            rot_auto_eoi <= 1'b0;
        end else if (init_start) begin
            poll_armed   <= 1'b0;
            read_isr     <= 1'b0;
            special_mask <= 1'b0;
            rot_auto_eoi <= 1'b0;
        end else begin
            if (poll_take) poll_armed <= 1'b0;
            if (is_sel) begin
                if (wdata[B_POLL])    poll_armed   <= 1'b1;
                if (wdata[B_RSEL_EN]) read_isr     <= wdata[B_RSEL];
                if (wdata[B_SMM_EN])  special_mask <= wdata[B_SMM];
            end
            if (is_ocw2 && code[1:0] == 2'b00) rot_auto_eoi <= code[2];
        end
    end

    assert_rsel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sel && wdata[B_RSEL_EN]) |=> read_isr == $past(wdata[B_RSEL]));

    assert_poll_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sel && wdata[B_POLL]) |=> poll_armed);

    assert_rot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ocw2 && code[1:0] == 2'b00) |=> rot_auto_eoi == $past(wdata[DATA_W-1]));

    assert_poll_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_take && !wr_ctl) |=> !poll_armed);

endmodule

// File: rtl/intc_read_port.sv
module intc_read_port
    import intc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_addr,
    input  logic              poll_armed,
    input  logic              pend_valid,
    input  logic [LINE_W-1:0] pend_line,
    input  logic [DATA_W-1:0] req_in,
    input  logic [DATA_W-1:0] isr_in,
    input  logic [DATA_W-1:0] mask_q,
    input  logic              read_isr,
    output logic [DATA_W-1:0] rdata,
    output cmd_op_t           rd_op,
    output logic [LINE_W-1:0] rd_line
);

    localparam logic [DATA_W-1:0] SPURIOUS = DATA_W'(DATA_W - 1);

    logic [DATA_W-1:0] rd_value;

    always_comb begin
        rd_op   = OP_NONE;
        rd_line = '0;
        if (poll_armed) begin
            if (pend_valid) begin
                rd_value = DATA_W'(pend_line);
                rd_op    = rd_en ? OP_POLL_ACK : OP_NONE;
                rd_line  = rd_en ? pend_line : '0;
            end else begin
                rd_value = SPURIOUS;
            end
        end else if (rd_addr) begin
            rd_value = mask_q;
        end else begin
            rd_value = read_isr ? isr_in : req_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_value;
    end

    assert_poll_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_armed && !pend_valid) |=> rdata == SPURIOUS);

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/intc_cmd_seq.sv
module intc_cmd_seq
    import intc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  req_in,
    input  logic [7:0]  isr_in,
    input  logic        pend_valid,
    input  logic [2:0]  pend_line,
    output logic [7:0]  vec_base,
    output logic [7:0]  mask_out,
    output logic        auto_eoi,
    output logic        nested_mode,
    output logic        rot_auto_eoi,
    output logic        special_mask,
    output logic        read_isr,
    output logic        poll_armed,
    output logic [2:0]  cmd_op,
    output logic [2:0]  cmd_line
);

    logic              wr_ctl, wr_dat, rd_en, init_start, poll_take;
    cmd_op_t           wr_op, rd_op, op_q;
    logic [LINE_W-1:0] wr_line, rd_line, line_q;

    assign wr_ctl    = bus_wr && !bus_addr;
    assign wr_dat    = bus_wr &&  bus_addr;
    assign rd_en     = bus_rd && !bus_wr;
    assign poll_take = rd_en && poll_armed;

    intc_init_fsm u_init (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctl      (wr_ctl),
        .wr_dat      (wr_dat),
        .wdata       (bus_wdata),
        .init_start  (init_start),
        .vec_base    (vec_base),
        .mask_q      (mask_out),
        .auto_eoi    (auto_eoi),
        .nested_mode (nested_mode)
    );

    intc_ocw_decode u_ocw (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ctl       (wr_ctl),
        .wdata        (bus_wdata),
        .init_start   (init_start),
        .poll_take    (poll_take),
        .poll_armed   (poll_armed),
        .read_isr     (read_isr),
        .special_mask (special_mask),
        .rot_auto_eoi (rot_auto_eoi),
        .wr_op        (wr_op),
        .wr_line      (wr_line)
    );

    intc_read_port u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_addr    (bus_addr),
        .poll_armed (poll_armed),
        .pend_valid (pend_valid),
        .pend_line  (pend_line),
        .req_in     (req_in),
        .isr_in     (isr_in),
        .mask_q     (mask_out),
        .read_isr   (read_isr),
        .rdata      (bus_rdata),
        .rd_op      (rd_op),
        .rd_line    (rd_line)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            line_q <= '0;
        end else if (init_start) begin
            op_q   <= OP_INIT;
            line_q <= '0;
        end else if (wr_ctl) begin
            op_q   <= wr_op;
            line_q <= wr_line;
        end else if (rd_en) begin
            op_q   <= rd_op;
            line_q <= rd_line;
        end else begin
            op_q   <= OP_NONE;
            line_q <= '0;
        end
    end

    assign cmd_op   = op_q;
    assign cmd_line = line_q;

    assert_cmd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !bus_rd) |=> cmd_op == OP_NONE);

    assert_init_op_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[B_INIT]) |=> (cmd_op == OP_INIT && !poll_armed));

    assert_poll_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && poll_armed && pend_valid)
        |=> (cmd_op == OP_POLL_ACK && cmd_line == $past(pend_line)));

endmodule

// File: tb/intc_cmd_seq_tb.sv
module intc_cmd_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, req_in = '0, isr_in = '0;
    logic       pend_valid = 1'b0;
    logic [2:0] pend_line = '0;
    logic [7:0] bus_rdata, vec_base, mask_out;
    logic       auto_eoi, nested_mode, rot_auto_eoi, special_mask, read_isr, poll_armed;
    logic [2:0] cmd_op, cmd_line;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    intc_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_in(req_in), .isr_in(isr_in),
        .pend_valid(pend_valid), .pend_line(pend_line), .vec_base(vec_base),
        .mask_out(mask_out), .auto_eoi(auto_eoi), .nested_mode(nested_mode),
        .rot_auto_eoi(rot_auto_eoi), .special_mask(special_mask), .read_isr(read_isr),
        .poll_armed(poll_armed), .cmd_op(cmd_op), .cmd_line(cmd_line)
    );

    // Behavioural reference model
    int       m_phase = 0;
    bit       m_more = 0;
    int       m_vec = 0, m_mask = 0, m_rd = 0, m_op = 0, m_line = 0;
    bit       m_aeoi = 0, m_nest = 0, m_rot = 0, m_smm = 0, m_risr = 0, m_poll = 0;

    always @(posedge clk) begin
        int code;
        if (!rst_n) begin
            m_phase = 0; m_more = 0; m_vec = 0; m_mask = 0; m_rd = 0; m_op = 0; m_line = 0;
            m_aeoi = 0; m_nest = 0; m_rot = 0; m_smm = 0; m_risr = 0; m_poll = 0;
        end else begin
            m_op = 0; m_line = 0;
            if (bus_wr && bus_addr == 0 && bus_wdata[4]) begin
                m_phase = 1; m_more = bus_wdata[0]; m_vec = 0; m_mask = 0;
                m_aeoi = 0; m_nest = 0; m_rot = 0; m_smm = 0; m_risr = 0; m_poll = 0;
                m_op = 1;
            end else if (bus_wr && bus_addr == 0 && bus_wdata[3]) begin
                if (bus_wdata[2]) m_poll = 1;
                if (bus_wdata[1]) m_risr = bus_wdata[0];
                if (bus_wdata[6]) m_smm = bus_wdata[5];
            end else if (bus_wr && bus_addr == 0) begin
                code = int'(bus_wdata[7:5]);
                if (code == 0 || code == 4) m_rot = bus_wdata[7];
                else if (code == 1) m_op = 2;
                else if (code == 5) m_op = 3;
                else if (code == 3) begin m_op = 4; m_line = int'(bus_wdata[2:0]); end
                else if (code == 6) begin m_op = 5; m_line = int'(bus_wdata[2:0]); end
                else if (code == 7) begin m_op = 6; m_line = int'(bus_wdata[2:0]); end
            end else if (bus_wr) begin
                if (m_phase == 0) m_mask = int'(bus_wdata);
                else if (m_phase == 1) begin m_vec = int'(bus_wdata) / 8 * 8; m_phase = 2; end
                else if (m_phase == 2) m_phase = m_more ? 3 : 0;
                else begin m_nest = bus_wdata[4]; m_aeoi = bus_wdata[1]; m_phase = 0; end
            end else if (bus_rd) begin
                if (m_poll) begin
                    m_poll = 0;
                    if (pend_valid) begin m_rd = int'(pend_line); m_op = 7; m_line = int'(pend_line); end
                    else m_rd = 7;
                end else if (bus_addr) m_rd = m_mask;
                else m_rd = m_risr ? int'(isr_in) : int'(req_in);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(vec_base) == m_vec, "R2 vec_base", int'(vec_base), m_vec);
            chk(int'(mask_out) == m_mask, "R5 mask_out", int'(mask_out), m_mask);
            chk(auto_eoi == m_aeoi, "R4 auto_eoi", auto_eoi, m_aeoi);
            chk(nested_mode == m_nest, "R4 nested_mode", nested_mode, m_nest);
            chk(read_isr == m_risr, "R6 read_isr", read_isr, m_risr);
            chk(special_mask == m_smm, "R6 special_mask", special_mask, m_smm);
            chk(poll_armed == m_poll, "R8 poll_armed", poll_armed, m_poll);
            chk(rot_auto_eoi == m_rot, "R7 rot_auto_eoi", rot_auto_eoi, m_rot);
            chk(int'(cmd_op) == m_op, "R7/R11 cmd_op", int'(cmd_op), m_op);
            chk(int'(cmd_line) == m_line, "R7 cmd_line", int'(cmd_line), m_line);
            chk(int'(bus_rdata) == m_rd, "R9 bus_rdata", int'(bus_rdata), m_rd);
        end
    end

    task automatic wr(input bit a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input bit a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(vec_base == 0 && mask_out == 0 && cmd_op == 0 && bus_rdata == 0 && !read_isr
            && !auto_eoi && !nested_mode && !poll_armed, "R10 reset", int'(mask_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 mask load in ready state
        wr(1, 8'hA5);
        chk(mask_out == 8'hA5, "R5 ready mask", int'(mask_out), 8'hA5);

        // R1..R4 full sequence with mode byte
        wr(0, 8'h11);
        chk(cmd_op == 3'd1 && mask_out == 0, "R1 init", int'(cmd_op), 1);
        @(negedge clk);
        chk(cmd_op == 3'd0, "R11 pulse", int'(cmd_op), 0);
        wr(1, 8'h4F);
        chk(vec_base == 8'h48, "R2 base", int'(vec_base), 8'h48);
        wr(1, 8'hFF);
        chk(mask_out == 0, "R3 cfg2 ignored", int'(mask_out), 0);
        wr(1, 8'h12);
        chk(nested_mode && auto_eoi, "R4 cfg3", {nested_mode, auto_eoi}, 3);
        wr(1, 8'h3C);
        chk(mask_out == 8'h3C, "R5 after init", int'(mask_out), 8'h3C);

        // R3 sequence without mode byte
        wr(0, 8'h10);
        wr(1, 8'h20);
        wr(1, 8'h77);
        wr(1, 8'h0F);
        chk(mask_out == 8'h0F && !auto_eoi, "R3 short seq", int'(mask_out), 8'h0F);

        // R6 selection commands and R9 reads
        req_in = 8'h81; isr_in = 8'h24;
        rd(0);
        chk(bus_rdata == 8'h81, "R9 req read", int'(bus_rdata), 8'h81);
        wr(0, 8'h0B);
        rd(0);
        chk(bus_rdata == 8'h24, "R9 isr read", int'(bus_rdata), 8'h24);
        wr(0, 8'h08);
        chk(read_isr, "R6 no change", read_isr, 1);
        wr(0, 8'h68);
        chk(special_mask, "R6 smm", special_mask, 1);
        rd(1);
        chk(bus_rdata == 8'h0F, "R9 mask read", int'(bus_rdata), 8'h0F);

        // R7 command codes
        for (int c = 0; c < 8; c++) begin
            wr(0, 8'((c << 5) | 5));
        end
        wr(0, 8'h80);
        chk(rot_auto_eoi, "R7 rot set", rot_auto_eoi, 1);
        wr(0, 8'hE6);
        chk(cmd_op == 3'd6 && cmd_line == 3'd6, "R7 rot spec", int'(cmd_op), 6);

        // R8 poll
        pend_valid = 1'b1; pend_line = 3'd5;
        wr(0, 8'h0C);
        rd(1);
        chk(bus_rdata == 8'd5 && cmd_op == 3'd7 && cmd_line == 3'd5, "R8 poll hit", int'(bus_rdata), 5);
        rd(0);
        chk(bus_rdata == 8'h24, "R8 poll once", int'(bus_rdata), 8'h24);
        pend_valid = 1'b0;
        wr(0, 8'h0C);
        rd(0);
        chk(bus_rdata == 8'd7 && cmd_op == 3'd0, "R8 spurious", int'(bus_rdata), 7);

        // R11 write wins over read
        bus_addr = 1'b1; bus_wdata = 8'h99; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk(mask_out == 8'h99 && bus_rdata == 8'd7, "R11 wr priority", int'(bus_rdata), 7);

        // R1 init cancels modes mid-sequence
        wr(0, 8'h11);
        wr(0, 8'h13);
        chk(cmd_op == 3'd1 && !rot_auto_eoi && !special_mask, "R1 restart", int'(cmd_op), 1);
        wr(1, 8'h08);
        wr(1, 8'h00);
        wr(1, 8'h02);
        chk(auto_eoi && !nested_mode && vec_base == 8'h08, "R4 aeoi only", int'(vec_base), 8);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule